// File: doc/BRIEF.md
# Multi-Port Histogram Accumulator

This block collects increments from several parallel sources into one shared histogram. In each sample period every source may offer one update: a bin index, an amount, and a valid flag. All offered updates are taken at the same moment when `sample_i` is raised while the block is idle. The block then replays them one at a time in fixed time slots, so several sources that hit the same bin in the same period all add to it and none of them is lost.

The sources are split into groups of `SRC_PER_BANK`. Each group owns a partial memory, and inside a group each source has its own read-modify-write slot. The partial memories run their slots side by side. A read sums the matching bin of every partial memory to give the composite count. A clear command zeroes every bin by walking the bin addresses. The same walk runs on its own after reset. While the block is capturing, draining or clearing, it raises `busy_o`.

Top module: `hist_accum`

## Requirements
- R1: Every valid update adds its amount to its bin. After the period completes, a read of that bin returns the previous composite value plus the amount. Source i uses `upd_bin_i[i*BIN_AW +: BIN_AW]`, `upd_inc_i[i*INC_W +: INC_W]` and `upd_vld_i[i]`.
- R2: When several valid sources name the same bin in one period, the bin grows by the sum of all their amounts.
- R3: A source whose valid bit is 0 changes no bin, whatever bin and amount it carries.
- R4: `rd_sum_o` shows the sum over all partial memories of the bin that `rd_bin_i` held at the previous rising clock edge.
- R5: `sample_i` is taken only while `busy_o` is low. A `sample_i` raised while busy is ignored and adds nothing.
- R6: An accepted sample keeps `busy_o` high for exactly `SRC_PER_BANK + 1` cycles: one slot per source of a group, plus one drain cycle. Once `busy_o` falls, every update of the period is visible to reads.
- R7: `clear_i` raised while idle keeps `busy_o` high for `NUM_BINS` cycles. Afterwards every bin reads 0.
- R8: After reset is released, `busy_o` stays high for `NUM_BINS` cycles. Afterwards every bin reads 0.
- R9: When `clear_i` and `sample_i` are both high in the same idle cycle, the clear is performed and the sample is dropped.
- R10: Two consecutive slots that update the same bin of one partial memory both count. The second read takes the value the first is still writing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_i | input | 1 | Capture all source updates and start a period |
| upd_vld_i | input | NUM_SRC | Per-source valid bit |
| upd_bin_i | input | NUM_SRC*BIN_AW | Per-source bin index, source i at `[i*BIN_AW +: BIN_AW]` |
| upd_inc_i | input | NUM_SRC*INC_W | Per-source amount, source i at `[i*INC_W +: INC_W]` |
| clear_i | input | 1 | Zero all bins |
| busy_o | output | 1 | Capturing, draining or clearing |
| rd_bin_i | input | BIN_AW | Bin index to read |
| rd_sum_o | output | BIN_W+clog2(NUM_SRC/SRC_PER_BANK) | Composite bin value |

## Verification
The assertions assume that `sample_i` and `clear_i` only start work when `busy_o` is low. The stimulus waits for `busy_o` to fall before every new period or clear, except in the deliberate busy-time pulse. The assertions also assume that reads are meaningful only while idle, so the bench issues every read after `busy_o` has dropped. Random amounts stay small enough that no partial bin wraps within a run.

// File: rtl/hist_pkg.sv
package hist_pkg;

  typedef enum logic [1:0] {
    ST_CLEAR = 2'd0,
    ST_IDLE  = 2'd1,
    ST_RUN   = 2'd2,
    ST_DRAIN = 2'd3
  } seq_state_e;

  // Source served by a given bank in a given slot
  function automatic int lane_index(input int bank, input int slot, input int per_bank);
    return bank * per_bank + slot;
  endfunction

endpackage

// File: rtl/hist_capture.sv
module hist_capture #(
  parameter int NUM_SRC = 8,
  parameter int BIN_AW  = 4,
  parameter int INC_W   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [NUM_SRC-1:0]        vld_i,
  input  logic [NUM_SRC*BIN_AW-1:0] bin_i,
  input  logic [NUM_SRC*INC_W-1:0]  inc_i,
  output logic [NUM_SRC-1:0]        vld_q,
  output logic [NUM_SRC*BIN_AW-1:0] bin_q,
  output logic [NUM_SRC*INC_W-1:0]  inc_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      bin_q <= '0;
      inc_q <= '0;
    end else if (load) begin
      vld_q <= vld_i;
      bin_q <= bin_i;
      inc_q <= inc_i;
    end
  end

endmodule

// File: rtl/hist_bank.sv
module hist_bank #(
  parameter int NUM_BINS = 16,
  parameter int BIN_AW   = 4,
  parameter int INC_W    = 8,
  parameter int BIN_W    = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_vld,
  input  logic [BIN_AW-1:0] slot_bin,
  input  logic [INC_W-1:0]  slot_inc,
  input  logic              clr_en,
  input  logic [BIN_AW-1:0] clr_bin,
  input  logic [BIN_AW-1:0] rd_bin,
  output logic [BIN_W-1:0]  rd_val,
  output logic              pend_o
);

  function automatic logic [BIN_W-1:0] bin_add(input logic [BIN_W-1:0] base,
                                               input logic [INC_W-1:0] inc);
    return base + BIN_W'(inc);
  endfunction

  logic [BIN_W-1:0]  mem [NUM_BINS];
  logic              s1_vld_q;
  logic [BIN_AW-1:0] s1_bin_q;
  logic [INC_W-1:0]  s1_inc_q;
  logic [BIN_W-1:0]  s1_base_q;

  logic              wr_en;
  logic [BIN_AW-1:0] wr_bin;
  logic [BIN_W-1:0]  wr_data;
  logic              fwd_hit;

  assign wr_en   = s1_vld_q;
  assign wr_bin  = s1_bin_q;
  assign wr_data = bin_add(s1_base_q, s1_inc_q);
  assign fwd_hit = wr_en && (wr_bin == slot_bin);
  assign pend_o  = s1_vld_q;

  // Read stage of the read-modify-write, with bypass of the write in flight
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q  <= 1'b0;
      s1_bin_q  <= '0;
      s1_inc_q  <= '0;
      s1_base_q <= '0;
    end else begin
      s1_vld_q  <= slot_vld;
      s1_bin_q  <= slot_bin;
      s1_inc_q  <= slot_inc;
      s1_base_q <= fwd_hit ? wr_data : mem[slot_bin];
    end
  end

  always_ff @(posedge clk) begin
    if (clr_en)     mem[clr_bin] <= '0;
    else if (wr_en) mem[wr_bin]  <= wr_data;
  end

  always_ff @(posedge clk) begin
    rd_val <= mem[rd_bin];
  end

  // R10
  fwd_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_vld && wr_en && (wr_bin == slot_bin)) |=> (s1_base_q == $past(wr_data)));

  // R7
  wr_clr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr_en && wr_en));

endmodule

// File: rtl/hist_accum.sv
module hist_accum
  import hist_pkg::*;
#(
  parameter int NUM_SRC      = 8,
  parameter int SRC_PER_BANK = 4,
  parameter int NUM_BINS     = 16,
  parameter int BIN_AW       = 4,
  parameter int INC_W        = 8,
  parameter int BIN_W        = 24,
  localparam int NUM_BANK    = NUM_SRC / SRC_PER_BANK,
  localparam int SUM_W       = BIN_W + $clog2(NUM_BANK),
  localparam int SLOT_W      = (SRC_PER_BANK > 1) ? $clog2(SRC_PER_BANK) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sample_i,
  input  logic [NUM_SRC-1:0]        upd_vld_i,
  input  logic [NUM_SRC*BIN_AW-1:0] upd_bin_i,
  input  logic [NUM_SRC*INC_W-1:0]  upd_inc_i,
  input  logic                      clear_i,
  output logic                      busy_o,
  input  logic [BIN_AW-1:0]         rd_bin_i,
  output logic [SUM_W-1:0]          rd_sum_o
);

  seq_state_e        state_q;
  logic [SLOT_W-1:0] slot_q;
  logic [BIN_AW-1:0] clr_ptr_q;
  logic              start_smp;
  logic              start_clr;
  logic              in_run;
  logic              in_clear;

  logic [NUM_SRC-1:0]        hold_vld;
  logic [NUM_SRC*BIN_AW-1:0] hold_bin;
  logic [NUM_SRC*INC_W-1:0]  hold_inc;

  logic [BIN_W-1:0]  bank_rd   [NUM_BANK];
  logic [NUM_BANK-1:0] bank_pend;

  assign busy_o    = (state_q != ST_IDLE);
  assign in_run    = (state_q == ST_RUN);
  assign in_clear  = (state_q == ST_CLEAR);
  assign start_clr = (state_q == ST_IDLE) && clear_i;
  assign start_smp = (state_q == ST_IDLE) && sample_i && !clear_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_CLEAR;
      slot_q    <= '0;
      clr_ptr_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          slot_q    <= '0;
          clr_ptr_q <= '0;
          if (start_clr)      state_q <= ST_CLEAR;
          else if (start_smp) state_q <= ST_RUN;
        end
        ST_RUN: begin
          slot_q <= slot_q + 1'b1;
          if (slot_q == SLOT_W'(SRC_PER_BANK - 1)) state_q <= ST_DRAIN;
        end
        ST_DRAIN: state_q <= ST_IDLE;
        ST_CLEAR: begin
          clr_ptr_q <= clr_ptr_q + 1'b1;
          if (clr_ptr_q == BIN_AW'(NUM_BINS - 1)) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  hist_capture #(.NUM_SRC(NUM_SRC), .BIN_AW(BIN_AW), .INC_W(INC_W)) u_capture (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start_smp),
    .vld_i (upd_vld_i),
    .bin_i (upd_bin_i),
    .inc_i (upd_inc_i),
    .vld_q (hold_vld),
    .bin_q (hold_bin),
    .inc_q (hold_inc)
  );

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    int                lane;
    logic              s_vld;
    logic [BIN_AW-1:0] s_bin;
    logic [INC_W-1:0]  s_inc;

    always_comb begin
      lane  = lane_index(b, int'(slot_q), SRC_PER_BANK);
      s_vld = in_run && hold_vld[lane];
      s_bin = hold_bin[lane*BIN_AW +: BIN_AW];
      s_inc = hold_inc[lane*INC_W +: INC_W];
    end

    hist_bank #(.NUM_BINS(NUM_BINS), .BIN_AW(BIN_AW), .INC_W(INC_W), .BIN_W(BIN_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .slot_vld (s_vld),
      .slot_bin (s_bin),
      .slot_inc (s_inc),
      .clr_en   (in_clear),
      .clr_bin  (clr_ptr_q),
      .rd_bin   (rd_bin_i),
      .rd_val   (bank_rd[b]),
      .pend_o   (bank_pend[b])
    );
  end

  // Composite read: add the partial memories together
  always_comb begin
    rd_sum_o = '0;
    for (int b = 0; b < NUM_BANK; b++) rd_sum_o = rd_sum_o + SUM_W'(bank_rd[b]);
  end

  // R5
  sample_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_run) |-> $past(!busy_o));

  // R6
  slot_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && slot_q != SLOT_W'(SRC_PER_BANK - 1)) |=> (in_run && slot_q == $past(slot_q) + 1'b1));

  // R6
  idle_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (bank_pend == '0));

  // R9
  clear_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_clear) |-> !$past(in_run));

endmodule

// File: tb/hist_accum_tb.sv
module hist_accum_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 8;
  localparam int SPB  = 4;
  localparam int NB   = 16;
  localparam int AW   = 4;
  localparam int IW   = 8;
  localparam int BW   = 24;
  localparam int SW   = BW + 1;

  logic clk = 0;
  logic rst_n = 0;
  logic sample_i = 0;
  logic clear_i = 0;
  logic [NSRC-1:0] upd_vld_i = '0;
  logic [NSRC*AW-1:0] upd_bin_i = '0;
  logic [NSRC*IW-1:0] upd_inc_i = '0;
  logic busy_o;
  logic [AW-1:0] rd_bin_i = '0;
  logic [SW-1:0] rd_sum_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  longint expv [NB];

  always #(CLK_PERIOD/2) clk = ~clk;

  hist_accum #(.NUM_SRC(NSRC), .SRC_PER_BANK(SPB), .NUM_BINS(NB), .BIN_AW(AW),
               .INC_W(IW), .BIN_W(BW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .upd_vld_i(upd_vld_i),
    .upd_bin_i(upd_bin_i), .upd_inc_i(upd_inc_i), .clear_i(clear_i),
    .busy_o(busy_o), .rd_bin_i(rd_bin_i), .rd_sum_o(rd_sum_o));

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy_o && n < 10000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic read_bin(input int b, output longint v);
    rd_bin_i = AW'(b);
    @(negedge clk);
    v = longint'(rd_sum_o);
  endtask

  task automatic check_all(input string req);
    longint v;
    for (int b = 0; b < NB; b++) begin
      read_bin(b, v);
      check(req, v, expv[b]);
    end
  endtask

  // Model: add every valid source amount into its bin
  function automatic void model_add(input logic [NSRC-1:0] v, input logic [NSRC*AW-1:0] bn,
                                    input logic [NSRC*IW-1:0] inc);
    for (int i = 0; i < NSRC; i++)
      if (v[i]) expv[bn[i*AW +: AW]] += longint'(inc[i*IW +: IW]);
  endfunction

  task automatic period(input logic [NSRC-1:0] v, input logic [NSRC*AW-1:0] bn,
                        input logic [NSRC*IW-1:0] inc, input string req);
    int n;
    upd_vld_i = v; upd_bin_i = bn; upd_inc_i = inc; sample_i = 1;
    @(negedge clk);
    sample_i = 0;
    count_busy(n);
    check({req, " busy"}, n, SPB + 1);
    model_add(v, bn, inc);
  endtask

  initial begin
    int n;
    logic [NSRC*AW-1:0] bn;
    logic [NSRC*IW-1:0] inc;
    void'($urandom(32'd4242));
    for (int b = 0; b < NB; b++) expv[b] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R8: reset walk
    count_busy(n);
    check("R8 busy", n, NB);
    check_all("R8");

    // R1: one source
    bn = '0; inc = '0;
    bn[3*AW +: AW] = 4'd5; inc[3*IW +: IW] = 8'd7;
    period(8'h08, bn, inc, "R6");
    check_all("R1 R4");

    // R2 R10: all sources on one bin, consecutive slots in each bank
    for (int i = 0; i < NSRC; i++) begin
      bn[i*AW +: AW] = 4'd9; inc[i*IW +: IW] = IW'(i + 1);
    end
    period('1, bn, inc, "R10");
    check_all("R2 R10");

    // R3: invalid sources carry data but must not count
    for (int i = 0; i < NSRC; i++) begin
      bn[i*AW +: AW] = AW'(i); inc[i*IW +: IW] = 8'd200;
    end
    period(8'h55, bn, inc, "R3");
    check_all("R3");

    // R5: sample raised while busy is ignored
    bn = '0; inc = '0;
    bn[0 +: AW] = 4'd2; inc[0 +: IW] = 8'd11;
    upd_vld_i = 8'h01; upd_bin_i = bn; upd_inc_i = inc; sample_i = 1;
    @(negedge clk);
    upd_vld_i = '1; upd_inc_i = {NSRC{8'd99}};
    @(negedge clk);
    sample_i = 0;
    count_busy(n);
    model_add(8'h01, bn, inc);
    check_all("R5");

    // R7: clear
    clear_i = 1;
    @(negedge clk);
    clear_i = 0;
    count_busy(n);
    check("R7 busy", n, NB);
    for (int b = 0; b < NB; b++) expv[b] = 0;
    check_all("R7");

    // R9: clear and sample together -> clear wins
    period('1, bn, inc, "R1");
    upd_vld_i = '1; sample_i = 1; clear_i = 1;
    @(negedge clk);
    sample_i = 0; clear_i = 0;
    count_busy(n);
    check("R9 busy", n, NB);
    for (int b = 0; b < NB; b++) expv[b] = 0;
    check_all("R9");

    // R1 R2: random periods
    for (int k = 0; k < 30; k++) begin
      logic [NSRC-1:0] v;
      v = NSRC'($urandom);
      for (int i = 0; i < NSRC; i++) begin
        bn[i*AW +: AW]  = AW'($urandom % 4);
        inc[i*IW +: IW] = IW'($urandom);
      end
      period(v, bn, inc, "R6");
      if (k % 5 == 4) check_all("R1 R2 R4");
    end
    check_all("R1 R2");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule